// File: doc/BRIEF.md
# Waveform Timer Channel

A 16-bit timer channel that turns a count tick into two programmable output levels. The counter runs in one of four modes: free-running up, up with restart when it matches the period register, up/down bouncing at the counter maximum, or up/down bouncing at the period register. Five kinds of events act on the two outputs: a match against compare register A, B or C, an edge on a selectable external line, and a software trigger. Each event drives each output with its own 2-bit action.

Software programs the channel through a write-only register bus. It reads results from a status word and the live count. A match on the period register can also halt the counter until the next trigger, or turn its clock off until software enables it again. A software trigger, or an external edge when triggering is enabled, restarts the count at zero.

Top module: `tc_wave_gen`

## Requirements
- R1: After reset the count is 0, both outputs are low, the status word is 0 and the counter clock is disabled.
- R2: A write to address 0 issues commands: bit 0 enables the counter clock, bit 1 disables it and wins if both are set. While the clock is enabled and the counter is not halted, the count changes by one step on each cycle with tick_i high, and holds otherwise.
- R3: Mode field bits [1:0] at address 1 select the count mode. Mode 0 counts up and wraps from 0xFFFF to 0. Mode 1 counts up and returns to 0 on the step after the count equals the period register (address 4). Every step taken at 0xFFFF sets status bit 0.
- R4: Modes 2 and 3 count up and down. Counting up, the direction turns to down at the top value (0xFFFF in mode 2, the period register in mode 3). Counting down, it turns to up at 0. A top value of 0 holds the count at 0.
- R5: Status bits 2, 3 and 4 record a counting step taken while the count equals register A (address 2), B (address 3) or the period register. All flags stay set until a write to address 5 clears each flag whose bit is 1 in the data. A new event in the same cycle keeps its flag set.
- R6: Output A applies a 2-bit action (0 none, 1 set, 2 clear, 3 toggle) from mode bits [10:9] on a software trigger, [12:11] on an external event, [14:13] on a period match and [16:15] on a register A match.
- R7: Output B applies the same action codes from mode bits [18:17] (software trigger), [20:19] (external event), [22:21] (period match) and [24:23] (register B match).
- R8: When events with a non-zero action coincide on one output, only the highest-priority one acts. The order is software trigger, external event, period match, then the register A or B match. An event whose action is 0 lets a lower-priority event through.
- R9: Mode bits [5:4] pick the external line: 0 is evt_b_i, and 1 to 3 are xclk_i bits 0 to 2. Bits [7:6] pick the edge that makes an event: 0 none, 1 rising, 2 falling, 3 either.
- R10: A software trigger (address 0, bit 2) restarts the count at 0 counting up, and clears a halt. So does an external event while mode bit 8 is set. A restart overrides a counting step in the same cycle.
- R11: A period match halts counting until the next trigger or enable command when mode bit 2 is set. It disables the counter clock when mode bit 3 is set. An enable command in the same cycle keeps the clock on.
- R12: Status bit 16 shows whether the counter clock is enabled. Bits 17 and 18 show the levels of outputs A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count tick, one step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| evt_b_i | input | 1 | External event line, source code 0 |
| xclk_i | input | 3 | External event lines, source codes 1 to 3 |
| count_o | output | 16 | Current count |
| wave_a_o | output | 1 | Output A level |
| wave_b_o | output | 1 | Output B level |
| status_o | output | 32 | Event flags, clock state and output levels |

## Verification
The assertions check the invariants that hold on every cycle. The count holds without a tick, while halted or while disabled. A restart always lands on zero. The up modes only step by one or return to zero. An output never moves in a cycle without one of its events. The period-match flag is sticky. The bench covers what needs a whole scenario: where the up/down counter turns at both ends, how each action code plays out over many periods, how coincident events resolve, how an edge is picked on each source line, and how halt and disable interact with triggers and enable commands. A reference model in the bench checks all of this against the design.

// File: rtl/tc_wave_pkg.sv
package tc_wave_pkg;
  localparam int MODE_W = 25;
  localparam int ST_W   = 32;

  localparam int ADR_CTRL = 0;
  localparam int ADR_MODE = 1;
  localparam int ADR_RA   = 2;
  localparam int ADR_RB   = 3;
  localparam int ADR_RC   = 4;
  localparam int ADR_CLR  = 5;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  function automatic logic act_apply(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/tc_wave_regs.sv
module tc_wave_regs
  import tc_wave_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [CW-1:0]     ra_o,
  output logic [CW-1:0]     rb_o,
  output logic [CW-1:0]     rc_o,
  output logic              en_cmd_o,
  output logic              dis_cmd_o,
  output logic              sw_cmd_o,
  output logic [4:0]        clr_o
);
  logic ctrl_hit, clr_hit;
  logic unused_hi;

  assign unused_hi = ^wr_data_i[DW-1:MODE_W];
  assign ctrl_hit  = wr_en_i && (wr_addr_i == AW'(ADR_CTRL));
  assign clr_hit   = wr_en_i && (wr_addr_i == AW'(ADR_CLR));
  assign en_cmd_o  = ctrl_hit & wr_data_i[0];
  assign dis_cmd_o = ctrl_hit & wr_data_i[1];
  assign sw_cmd_o  = ctrl_hit & wr_data_i[2];
  assign clr_o     = clr_hit ? wr_data_i[4:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      ra_o   <= '0;
      rb_o   <= '0;
      rc_o   <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(ADR_MODE)) mode_o <= wr_data_i[MODE_W-1:0];
      if (wr_addr_i == AW'(ADR_RA))   ra_o   <= wr_data_i[CW-1:0];
      if (wr_addr_i == AW'(ADR_RB))   rb_o   <= wr_data_i[CW-1:0];
      if (wr_addr_i == AW'(ADR_RC))   rc_o   <= wr_data_i[CW-1:0];
    end
  end
endmodule

// File: rtl/tc_wave_evt.sv
module tc_wave_evt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] lines_i,
  input  logic [1:0] src_i,
  input  logic [1:0] edge_i,
  output logic       ev_o
);
  logic lvl, prev_q;

  assign lvl = lines_i[src_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  always_comb begin
    case (edge_i)
      2'd1:    ev_o = lvl & ~prev_q;
      2'd2:    ev_o = ~lvl & prev_q;
      2'd3:    ev_o = lvl ^ prev_q;
      default: ev_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tc_wave_cnt.sv
module tc_wave_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    wave_sel_i,
  input  logic [CW-1:0] ra_i,
  input  logic [CW-1:0] rb_i,
  input  logic [CW-1:0] rc_i,
  input  logic          trig_i,
  input  logic          en_cmd_i,
  input  logic          dis_cmd_i,
  input  logic          stop_on_c_i,
  input  logic          dis_on_c_i,
  output logic [CW-1:0] cnt_o,
  output logic          ev_a_o,
  output logic          ev_b_o,
  output logic          ev_c_o,
  output logic          ev_ovf_o,
  output logic          run_o,
  output logic          clk_en_o
);
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] top, nxt;
  logic up_q, up_nxt, stop_q, tk;

  assign run_o    = clk_en_o & ~stop_q;
  assign tk       = run_o & tick_i;
  assign ev_a_o   = tk && (cnt_o == ra_i);
  assign ev_b_o   = tk && (cnt_o == rb_i);
  assign ev_c_o   = tk && (cnt_o == rc_i);
  assign ev_ovf_o = tk && (cnt_o == MAXV);
  assign top      = wave_sel_i[0] ? rc_i : MAXV;

  always_comb begin
    nxt    = cnt_o + ONE;
    up_nxt = up_q;
    if (!wave_sel_i[1]) begin
      if (cnt_o == top) nxt = '0;
    end else if (up_q) begin
      if (cnt_o == top) begin
        up_nxt = 1'b0;
        nxt    = (cnt_o == '0) ? '0 : cnt_o - ONE;
      end
    end else if (cnt_o == '0) begin
      up_nxt = 1'b1;
      nxt    = (top == '0) ? '0 : ONE;
    end else begin
      nxt = cnt_o - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      up_q     <= 1'b1;
      clk_en_o <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      if (trig_i) begin
        cnt_o <= '0;
        up_q  <= 1'b1;
      end else if (tk) begin
        cnt_o <= nxt;
        up_q  <= up_nxt;
      end
      if (dis_cmd_i)                   clk_en_o <= 1'b0;
      else if (en_cmd_i)               clk_en_o <= 1'b1;
      else if (ev_c_o && dis_on_c_i)   clk_en_o <= 1'b0;
      if (trig_i || en_cmd_i)          stop_q <= 1'b0;
      else if (ev_c_o && stop_on_c_i)  stop_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tc_wave_out.sv
module tc_wave_out
  import tc_wave_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] ev_i,   // [0] highest priority
  input  logic [7:0] act_i,
  output logic       lvl_o
);
  logic nxt, hit;

  always_comb begin
    nxt = lvl_o;
    hit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (!hit && ev_i[i] && (act_e'(act_i[2*i +: 2]) != ACT_NONE)) begin
        nxt = act_apply(act_e'(act_i[2*i +: 2]), lvl_o);
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= 1'b0;
    else         lvl_o <= nxt;
  end
endmodule

// File: rtl/tc_wave_gen.sv
module tc_wave_gen
  import tc_wave_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            evt_b_i,
  input  logic [2:0]      xclk_i,
  output logic [CW-1:0]   count_o,
  output logic            wave_a_o,
  output logic            wave_b_o,
  output logic [ST_W-1:0] status_o
);
  logic [MODE_W-1:0] mode_w;
  logic [CW-1:0] ra_w, rb_w, rc_w;
  logic [4:0] clr_w;
  logic en_cmd, dis_cmd, sw_cmd, ev_x, trig_w, run_w, clk_en;
  logic ev_a, ev_b, ev_c, ev_ovf;
  logic [1:0] wave_sel_w, lvl_w, ev_any_w;
  logic ovf_q, cpa_q, cpb_q, cpc_q;

  tc_wave_regs #(.CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode_w), .ra_o(ra_w), .rb_o(rb_w), .rc_o(rc_w),
    .en_cmd_o(en_cmd), .dis_cmd_o(dis_cmd), .sw_cmd_o(sw_cmd), .clr_o(clr_w)
  );

  tc_wave_evt u_evt (
    .clk_i, .rst_ni, .lines_i({xclk_i, evt_b_i}),
    .src_i(mode_w[5:4]), .edge_i(mode_w[7:6]), .ev_o(ev_x)
  );

  assign wave_sel_w = mode_w[1:0];
  assign trig_w     = sw_cmd | (ev_x & mode_w[8]);

  tc_wave_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .wave_sel_i(wave_sel_w),
    .ra_i(ra_w), .rb_i(rb_w), .rc_i(rc_w), .trig_i(trig_w),
    .en_cmd_i(en_cmd), .dis_cmd_i(dis_cmd),
    .stop_on_c_i(mode_w[2]), .dis_on_c_i(mode_w[3]),
    .cnt_o(count_o), .ev_a_o(ev_a), .ev_b_o(ev_b), .ev_c_o(ev_c),
    .ev_ovf_o(ev_ovf), .run_o(run_w), .clk_en_o(clk_en)
  );

  for (genvar k = 0; k < 2; k++) begin : g_out
    logic [3:0] ev_vec;
    assign ev_vec      = {(k == 0) ? ev_a : ev_b, ev_c, ev_x, sw_cmd};
    assign ev_any_w[k] = |ev_vec;
    tc_wave_out u_out (
      .clk_i, .rst_ni, .ev_i(ev_vec),
      .act_i(mode_w[9 + 8*k +: 8]), .lvl_o(lvl_w[k])
    );
  end

  assign wave_a_o = lvl_w[0];
  assign wave_b_o = lvl_w[1];

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      cpa_q <= 1'b0;
      cpb_q <= 1'b0;
      cpc_q <= 1'b0;
    end else begin
      ovf_q <= ev_ovf | (ovf_q & ~clr_w[0]);
      cpa_q <= ev_a   | (cpa_q & ~clr_w[2]);
      cpb_q <= ev_b   | (cpb_q & ~clr_w[3]);
      cpc_q <= ev_c   | (cpc_q & ~clr_w[4]);
    end
  end

  always_comb begin
    status_o     = '0;
    status_o[0]  = ovf_q;
    status_o[2]  = cpa_q;
    status_o[3]  = cpb_q;
    status_o[4]  = cpc_q;
    status_o[16] = clk_en;
    status_o[17] = lvl_w[0];
    status_o[18] = lvl_w[1];
  end
endmodule

// File: rtl/tc_wave_gen_chk.sv
module tc_wave_gen_chk
  import tc_wave_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            wr_en_i,
  input logic [AW-1:0]   wr_addr_i,
  input logic [DW-1:0]   wr_data_i,
  input logic [CW-1:0]   count_o,
  input logic            wave_a_o,
  input logic            wave_b_o,
  input logic [ST_W-1:0] status_o,
  input logic            trig_w,
  input logic            run_w,
  input logic [1:0]      wave_sel_w,
  input logic [1:0]      ev_any_w
);
  logic clr_c;
  logic unused_chk;
  assign clr_c      = wr_en_i && (wr_addr_i == AW'(ADR_CLR)) && wr_data_i[4];
  assign unused_chk = ^{wr_data_i, status_o};

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !trig_w |=> $stable(count_o)); // R2
  AST_HOLD_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w && !trig_w |=> $stable(count_o)); // R11
  AST_TRIG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_w |=> count_o == '0); // R10
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w && tick_i && !trig_w && !wave_sel_w[1]
    |=> (count_o == $past(count_o) + 1'b1) || (count_o == '0)); // R3
  AST_A_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_any_w[0] |=> $stable(wave_a_o)); // R6
  AST_B_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_any_w[1] |=> $stable(wave_b_o)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] && !clr_c |=> status_o[4]); // R5
endmodule

bind tc_wave_gen tc_wave_gen_chk #(.CW(CW), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tc_wave_gen_tb.sv
module tc_wave_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, evt_b = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] xclk = '0;
  logic [15:0] count;
  logic wave_a, wave_b;
  logic [31:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0, m_ra = 0, m_rb = 0, m_rc = 0;
  bit m_up = 1, m_en = 0, m_stop = 0, m_a = 0, m_b = 0, m_prev = 0;
  bit m_ovf = 0, m_pa = 0, m_pb = 0, m_pc = 0;
  bit [31:0] m_mode = '0;

  always #5 clk = ~clk;

  tc_wave_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .evt_b_i(evt_b), .xclk_i(xclk),
    .count_o(count), .wave_a_o(wave_a), .wave_b_o(wave_b), .status_o(status)
  );

  function automatic bit do_act(int code, bit cur);
    if (code == 1) return 1'b1;
    if (code == 2) return 1'b0;
    if (code == 3) return !cur;
    return cur;
  endfunction

  function automatic bit pick(bit [3:0] ev, bit [7:0] acts, bit cur);
    for (int i = 0; i < 4; i++)
      if (ev[i] && acts[2*i +: 2] != 0) return do_act(int'(acts[2*i +: 2]), cur);
    return cur;
  endfunction

  task automatic model_step();
    bit [3:0] lines;
    bit lvl, ex, sw, enc, disc, clr, trig, tk, ea, eb, ec, ov, nu;
    int src, edg, top, n;
    bit [4:0] cm;
    lines = {xclk, evt_b};
    src = int'(m_mode[5:4]);
    edg = int'(m_mode[7:6]);
    lvl = lines[src];
    ex = (edg == 1 && lvl && !m_prev) || (edg == 2 && !lvl && m_prev) ||
         (edg == 3 && lvl != m_prev);
    sw   = wr_en && wr_addr == 0 && wr_data[2];
    enc  = wr_en && wr_addr == 0 && wr_data[0];
    disc = wr_en && wr_addr == 0 && wr_data[1];
    clr  = wr_en && wr_addr == 5;
    cm   = clr ? wr_data[4:0] : 5'b0;
    trig = sw || (ex && m_mode[8]);
    tk = m_en && !m_stop && tick;
    ea = tk && m_cnt == m_ra;
    eb = tk && m_cnt == m_rb;
    ec = tk && m_cnt == m_rc;
    ov = tk && m_cnt == 65535;
    top = m_mode[0] ? m_rc : 65535;
    n = m_cnt;
    nu = m_up;
    if (tk) begin
      if (!m_mode[1]) n = (m_cnt == top) ? 0 : (m_cnt + 1) % 65536;
      else if (m_up) begin
        if (m_cnt == top) begin nu = 0; n = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else n = (m_cnt + 1) % 65536;
      end else begin
        if (m_cnt == 0) begin nu = 1; n = (top == 0) ? 0 : 1; end
        else n = m_cnt - 1;
      end
    end
    if (trig) begin n = 0; nu = 1; end
    m_a = pick({ea, ec, ex, sw}, m_mode[16:9], m_a);
    m_b = pick({eb, ec, ex, sw}, m_mode[24:17], m_b);
    m_ovf = ov || (m_ovf && !cm[0]);
    m_pa  = ea || (m_pa && !cm[2]);
    m_pb  = eb || (m_pb && !cm[3]);
    m_pc  = ec || (m_pc && !cm[4]);
    if (disc) m_en = 0;
    else if (enc) m_en = 1;
    else if (ec && m_mode[3]) m_en = 0;
    if (trig || enc) m_stop = 0;
    else if (ec && m_mode[2]) m_stop = 1;
    if (wr_en && wr_addr == 1) m_mode = {7'b0, wr_data[24:0]};
    if (wr_en && wr_addr == 2) m_ra = int'(wr_data[15:0]);
    if (wr_en && wr_addr == 3) m_rb = int'(wr_data[15:0]);
    if (wr_en && wr_addr == 4) m_rc = int'(wr_data[15:0]);
    m_cnt = n;
    m_up = nu;
    m_prev = lvl;
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ra = 0; m_rb = 0; m_rc = 0; m_up = 1; m_en = 0; m_stop = 0;
    m_a = 0; m_b = 0; m_prev = 0; m_ovf = 0; m_pa = 0; m_pb = 0; m_pc = 0;
    m_mode = '0;
  endtask

  task automatic compare();
    bit [31:0] exp_st;
    exp_st = '0;
    exp_st[0] = m_ovf; exp_st[2] = m_pa; exp_st[3] = m_pb; exp_st[4] = m_pc;
    exp_st[16] = m_en; exp_st[17] = m_a; exp_st[18] = m_b;
    n_chk++;
    if (count !== 16'(m_cnt) || wave_a !== m_a || wave_b !== m_b || status !== exp_st) begin
      n_fail++;
      $display("FAIL %s: count=%h a=%b b=%b st=%h expected count=%h a=%b b=%b st=%h",
               cur_req, count, wave_a, wave_b, status, 16'(m_cnt), m_a, m_b, exp_st);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #2;
    if (rst_n && !done) compare();
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1"; idle(3);

    cur_req = "R2";
    wr(0, 1); tick = 1; idle(5); tick = 0; idle(3);
    for (int i = 0; i < 8; i++) begin tick = i[0]; idle(1); end
    tick = 1; wr(0, 2); idle(4); wr(0, 3); idle(2); wr(0, 1); idle(3);

    cur_req = "R3";
    wr(1, 0); idle(65540);
    wr(4, 5); wr(1, 1); wr(0, 4); idle(20);

    cur_req = "R4";
    wr(4, 4); wr(1, 3); wr(0, 4); idle(22);
    wr(4, 0); wr(0, 4); idle(6);
    wr(4, 3); wr(1, 2); wr(0, 4); idle(12);

    cur_req = "R5";
    wr(5, 'h1f); idle(2);
    wr(2, 2); wr(3, 3); wr(4, 7); wr(1, 1); wr(0, 4); idle(10);
    for (int i = 0; i < 10; i++) wr(5, 'h1c);
    wr(5, 'h1d); idle(4);

    cur_req = "R6";
    wr(2, 3); wr(4, 9); wr(1, 1 | (1 << 15) | (2 << 13)); wr(0, 4); idle(30);
    wr(1, 1 | (3 << 15)); idle(30);

    cur_req = "R7";
    wr(3, 6); wr(1, 1 | (3 << 23) | (1 << 21)); idle(30);
    wr(1, 1 | (2 << 23) | (3 << 21)); idle(25);

    cur_req = "R8";
    wr(2, 6); wr(3, 6); wr(4, 6);
    wr(1, 1 | (1 << 15) | (2 << 13) | (1 << 23) | (3 << 9)); idle(20);
    for (int i = 0; i < 12; i++) begin wr(0, 4); idle(i % 4); end
    wr(1, 1 | (3 << 15) | (3 << 21) | (2 << 17)); idle(20);

    cur_req = "R9";
    wr(4, 1000); wr(1, 1 | (1 << 6) | (3 << 11) | (1 << 19)); idle(2);
    for (int i = 0; i < 8; i++) begin @(negedge clk); evt_b = ~evt_b; idle(2); end
    wr(1, 1 | (2 << 4) | (2 << 6) | (3 << 11) | (3 << 19)); idle(2);
    for (int i = 0; i < 8; i++) begin @(negedge clk); xclk[1] = ~xclk[1]; xclk[0] = ~xclk[0]; idle(1); end
    wr(1, 1 | (3 << 4) | (3 << 6) | (3 << 11)); idle(2);
    for (int i = 0; i < 6; i++) begin @(negedge clk); xclk[2] = ~xclk[2]; idle(2); end
    wr(1, 1 | (1 << 4) | (0 << 6) | (3 << 11)); idle(2);
    for (int i = 0; i < 6; i++) begin @(negedge clk); xclk[0] = ~xclk[0]; idle(2); end

    cur_req = "R10";
    wr(1, 1 | (1 << 6) | (1 << 8) | (3 << 11)); idle(15);
    for (int i = 0; i < 6; i++) begin @(negedge clk); evt_b = ~evt_b; idle(7); end
    wr(0, 4); idle(5); tick = 0; wr(0, 4); idle(3); tick = 1; idle(4);

    cur_req = "R11";
    wr(4, 5); wr(1, 1 | (1 << 2) | (2 << 13)); wr(0, 4); idle(15);
    wr(0, 4); idle(12); wr(0, 1); idle(10);
    wr(1, 1 | (1 << 3) | (3 << 21)); wr(0, 4); idle(15);
    wr(0, 1); idle(10);

    cur_req = "R12";
    wr(1, 1 | (3 << 13) | (3 << 21)); wr(0, 1); idle(12);
    wr(0, 2); idle(4); wr(0, 1); idle(6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule